// File: doc/BRIEF.md
# Receive Lane Bring-Up Sequencer

This block powers up one serial receive lane without software help. On a start pulse it first asks for the transmit lane to come up and waits for the transmit side to acknowledge it. It then walks a PHY receive control word through a fixed series of single-step edits. First it takes software override and removes the receiver and auxiliary power-down controls and the sleep field. Then it launches calibration and waits, polling at a millisecond pace, for the PHY to clear the calibration-enable bit by itself.

Once calibration is over, the sequencer opens the receive data path and runs lock attempts. Each attempt pulses the clock-recovery reset, raises PHY-ready and samples the PCS block-lock indication. Attempts repeat at millisecond spacing until lock is seen or a retry limit runs out. The outcome is a `done` level or a 2-bit error code. Both are held, together with the control word, until the next start.

A parameter sets the number of clock cycles in one millisecond, so a short value can be used in simulation. Separate parameters set the calibration poll limit and the lock attempt limit.

Top module: `rx_lane_seq`

## Requirements
- R1: A synchronous reset sets `ctrl` to 0x000000F0, with bits 4 (receiver power-down), 5 (auxiliary power-down) and 7:6 (sleep) set and every other bit clear. Reset also drives `busy`, `done`, `tx_lane_en` and `err` to 0.
- R2: A start pulse while not busy clears `done` and `err`, reloads `ctrl` to the reset word, raises `tx_lane_en` and waits for `tx_ack` with `ctrl` unchanged. If `tx_fail` is seen during that wait (it takes priority over `tx_ack`), the run ends with `err` = 1 and `tx_lane_en` low.
- R3: From the cycle after the transmit acknowledge, `ctrl` takes one edit per cycle in this order: set bit 31, clear bit 4, clear bit 5, clear bits 7:6, set bit 8 (calibration enable).
- R4: The first calibration poll happens one cycle after bit 8 is set, and each later poll follows MS_CYCLES cycles of waiting. A poll that finds `phy_cal_busy` low ends calibration and clears bit 8 in the same cycle.
- R5: If CAL_TRIES polls all find `phy_cal_busy` high, the run ends with `err` = 2 and `ctrl` is left as it was.
- R6: Bit 0 (data enable) is set in the cycle after calibration completes and never while bit 8 is set. It is set before any clock-recovery reset pulse.
- R7: A lock attempt takes three cycles in this order: set bit 9 (clock-recovery reset), clear bit 9, set bit 10 (PHY-ready). `pcs_lock` is sampled in the cycle after that.
- R8: If lock is seen, `done` rises the next cycle. If it is absent, MS_CYCLES wait cycles pass and the attempt repeats, with bit 10 kept set. When LOCK_TRIES attempts have failed, the run ends with `err` = 3.
- R9: A start pulse while `busy` is high has no effect on `ctrl`, `busy`, `done`, `err` or `tx_lane_en`.
- R10: After the run ends, `ctrl`, `done`, `err` and `tx_lane_en` hold their values until the next start. At most one of `busy`, `done` and a non-zero `err` is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle request to begin bring-up |
| tx_ack | input | 1 | Transmit lane bring-up acknowledge |
| tx_fail | input | 1 | Transmit lane bring-up failure |
| phy_cal_busy | input | 1 | PHY readback of the calibration-enable bit; low means calibration finished |
| pcs_lock | input | 1 | PCS block-lock indication (link-status bit 6 of the wrapper status word) |
| ctrl | output | 32 | PHY receive control word |
| tx_lane_en | output | 1 | Transmit lane enable request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Bring-up finished with lock |
| err | output | 2 | 0 none, 1 transmit failure, 2 calibration timeout, 3 lock failure |

## Verification
The bench goes after the retry boundaries: calibration seen on the very last allowed poll, lock seen on the last allowed attempt, and one poll or attempt past those limits. A design whose counter is off by one would report a timeout one poll early or run one attempt too many. Waits of MS_CYCLES are timed cycle by cycle, so a timer that is one cycle short or long shows up at the next poll or attempt. The bench also sends a start pulse in the middle of a run, which a design that does not ignore it would restart. It covers a delayed transmit acknowledge, a transmit failure, and a restart after a failed run, which checks that the reset word is reloaded.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  localparam int WORD_W  = 32;
  localparam int B_DEN   = 0;
  localparam int B_PDN   = 4;
  localparam int B_APDN  = 5;
  localparam int B_SLP0  = 6;
  localparam int B_SLP1  = 7;
  localparam int B_CAL   = 8;
  localparam int B_CDR   = 9;
  localparam int B_RDY   = 10;
  localparam int B_OVRD  = 31;

  typedef enum logic [1:0] {
    E_NONE = 2'd0,
    E_TX   = 2'd1,
    E_CAL  = 2'd2,
    E_LOCK = 2'd3
  } err_t;

  typedef enum logic [4:0] {
    ST_IDLE, ST_TXW, ST_OVRD, ST_PDN, ST_APDN, ST_SLEEP, ST_CALGO,
    ST_CPOLL, ST_CWAIT, ST_DEN, ST_CDR_ON, ST_CDR_OFF, ST_RDY,
    ST_LOCK, ST_LWAIT, ST_DONE, ST_FAIL
  } st_t;

  // Word loaded at reset and at every accepted start.
  function automatic logic [WORD_W-1:0] word_at_reset();
    logic [WORD_W-1:0] w;
    w         = '0;
    w[B_PDN]  = 1'b1;
    w[B_APDN] = 1'b1;
    w[B_SLP0] = 1'b1;
    w[B_SLP1] = 1'b1;
    return w;
  endfunction

  // Single edit applied by each step state.
  function automatic logic [WORD_W-1:0] word_step(st_t s, logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = w;
    case (s)
      ST_OVRD:    r[B_OVRD] = 1'b1;
      ST_PDN:     r[B_PDN]  = 1'b0;
      ST_APDN:    r[B_APDN] = 1'b0;
      ST_SLEEP:   r[B_SLP1:B_SLP0] = 2'b00;
      ST_CALGO:   r[B_CAL]  = 1'b1;
      ST_CPOLL:   r[B_CAL]  = 1'b0;
      ST_DEN:     r[B_DEN]  = 1'b1;
      ST_CDR_ON:  r[B_CDR]  = 1'b1;
      ST_CDR_OFF: r[B_CDR]  = 1'b0;
      ST_RDY:     r[B_RDY]  = 1'b1;
      default:    r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rxseq_ms_timer.sv
module rxseq_ms_timer #(
  parameter int MS_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int TW = (MS_CYCLES > 2) ? $clog2(MS_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(MS_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run)   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/rxseq_try_counter.sv
module rxseq_try_counter #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic at_last
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bump)  cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == LAST);
endmodule

// File: rtl/rx_lane_seq.sv
module rx_lane_seq
  import rxseq_pkg::*;
#(
  parameter int MS_CYCLES  = 50000,
  parameter int CAL_TRIES  = 1000,
  parameter int LOCK_TRIES = 300
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        tx_ack,
  input  logic        tx_fail,
  input  logic        phy_cal_busy,
  input  logic        pcs_lock,
  output logic [31:0] ctrl,
  output logic        tx_lane_en,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err
);

  st_t               st, st_n;
  logic [WORD_W-1:0] ctrl_q, ctrl_n;
  err_t              err_q, err_n;
  logic              txen_q, txen_n;

  logic tmr_clr, tmr_run, ms_tick;
  logic cal_clr, cal_bump, cal_last;
  logic lk_clr, lk_bump, lk_last;

  // Named events for the checker.
  logic idle_like, tx_ok_ev, cal_poll_ev, cal_seen, lock_try_ev, lock_seen;

  assign idle_like   = (st == ST_IDLE) || (st == ST_DONE) || (st == ST_FAIL);
  assign tx_ok_ev    = (st == ST_TXW) && tx_ack && !tx_fail;
  assign cal_poll_ev = (st == ST_CPOLL);
  assign cal_seen    = cal_poll_ev && !phy_cal_busy;
  assign lock_try_ev = (st == ST_LOCK);
  assign lock_seen   = lock_try_ev && pcs_lock;

  rxseq_ms_timer #(.MS_CYCLES(MS_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .run(tmr_run), .tick(ms_tick)
  );

  rxseq_try_counter #(.LIMIT(CAL_TRIES)) u_cal_tries (
    .clk(clk), .rst(rst), .clr(cal_clr), .bump(cal_bump), .at_last(cal_last)
  );

  rxseq_try_counter #(.LIMIT(LOCK_TRIES)) u_lock_tries (
    .clk(clk), .rst(rst), .clr(lk_clr), .bump(lk_bump), .at_last(lk_last)
  );

  always_comb begin
    st_n     = st;
    ctrl_n   = ctrl_q;
    err_n    = err_q;
    txen_n   = txen_q;
    tmr_clr  = 1'b0;
    tmr_run  = 1'b0;
    cal_clr  = 1'b0;
    cal_bump = 1'b0;
    lk_clr   = 1'b0;
    lk_bump  = 1'b0;
    case (st)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          st_n   = ST_TXW;
          ctrl_n = word_at_reset();
          err_n  = E_NONE;
          txen_n = 1'b1;
        end
      end
      ST_TXW: begin
        if (tx_fail) begin
          st_n   = ST_FAIL;
          err_n  = E_TX;
          txen_n = 1'b0;
        end else if (tx_ack) begin
          st_n = ST_OVRD;
        end
      end
      ST_OVRD:  begin ctrl_n = word_step(st, ctrl_q); st_n = ST_PDN;   end
      ST_PDN:   begin ctrl_n = word_step(st, ctrl_q); st_n = ST_APDN;  end
      ST_APDN:  begin ctrl_n = word_step(st, ctrl_q); st_n = ST_SLEEP; end
      ST_SLEEP: begin ctrl_n = word_step(st, ctrl_q); st_n = ST_CALGO; end
      ST_CALGO: begin
        ctrl_n  = word_step(st, ctrl_q);
        cal_clr = 1'b1;
        st_n    = ST_CPOLL;
      end
      ST_CPOLL: begin
        if (cal_seen) begin
          ctrl_n = word_step(st, ctrl_q);
          st_n   = ST_DEN;
        end else begin
          cal_bump = 1'b1;
          if (cal_last) begin
            st_n  = ST_FAIL;
            err_n = E_CAL;
          end else begin
            st_n    = ST_CWAIT;
            tmr_clr = 1'b1;
          end
        end
      end
      ST_CWAIT: begin
        tmr_run = 1'b1;
        if (ms_tick) st_n = ST_CPOLL;
      end
      ST_DEN: begin
        ctrl_n = word_step(st, ctrl_q);
        lk_clr = 1'b1;
        st_n   = ST_CDR_ON;
      end
      ST_CDR_ON:  begin ctrl_n = word_step(st, ctrl_q); st_n = ST_CDR_OFF; end
      ST_CDR_OFF: begin ctrl_n = word_step(st, ctrl_q); st_n = ST_RDY;     end
      ST_RDY:     begin ctrl_n = word_step(st, ctrl_q); st_n = ST_LOCK;    end
      ST_LOCK: begin
        if (lock_seen) begin
          st_n = ST_DONE;
        end else begin
          lk_bump = 1'b1;
          if (lk_last) begin
            st_n  = ST_FAIL;
            err_n = E_LOCK;
          end else begin
            st_n    = ST_LWAIT;
            tmr_clr = 1'b1;
          end
        end
      end
      ST_LWAIT: begin
        tmr_run = 1'b1;
        if (ms_tick) st_n = ST_CDR_ON;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      ctrl_q <= word_at_reset();
      err_q  <= E_NONE;
      txen_q <= 1'b0;
    end else begin
      st     <= st_n;
      ctrl_q <= ctrl_n;
      err_q  <= err_n;
      txen_q <= txen_n;
    end
  end

  assign ctrl       = ctrl_q;
  assign tx_lane_en = txen_q;
  assign busy       = !idle_like;
  assign done       = (st == ST_DONE);
  assign err        = err_q;

endmodule

// File: rtl/rx_lane_seq_chk.sv
module rx_lane_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [31:0] ctrl,
  input logic        busy,
  input logic        done,
  input logic [1:0]  err,
  input logic        lock_try_ev
);
  localparam logic [31:0] RST_WORD = 32'h0000_00F0;

  assert_rst_word_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ctrl == RST_WORD && !busy && !done && err == 2'd0));

  // R2, R3: nothing moves in the word before override is taken
  assert_no_early_rx_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && !ctrl[31]) |-> (ctrl == RST_WORD));

  assert_data_after_cal_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl[0] |-> !ctrl[8]);

  assert_cdr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl[10]) |-> (!$past(ctrl[9]) && $past(ctrl[9], 2)));

  assert_sample_ready_R7: assert property (@(posedge clk) disable iff (rst)
    lock_try_ev |-> (ctrl[10] && ctrl[0] && !ctrl[9]));

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy, done, (err != 2'd0)}));

  assert_ignore_start_R9: assert property (@(posedge clk) disable iff (rst)
    (start && busy && ctrl[31]) |=> ctrl[31]);
endmodule

bind rx_lane_seq rx_lane_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .busy(busy),
  .done(done), .err(err), .lock_try_ev(lock_try_ev)
);

// File: tb/tb_rx_lane_seq.sv
module tb_rx_lane_seq;
  localparam int MS  = 3;
  localparam int CT  = 5;
  localparam int LT  = 4;
  localparam logic [31:0] RSTW = 32'h0000_00F0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, tx_ack = 1'b0, tx_fail = 1'b0;
  logic phy_cal_busy = 1'b1, pcs_lock = 1'b0;
  logic [31:0] ctrl;
  logic tx_lane_en, busy, done;
  logic [1:0] err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_lane_seq #(.MS_CYCLES(MS), .CAL_TRIES(CT), .LOCK_TRIES(LT)) dut (
    .clk(clk), .rst(rst), .start(start), .tx_ack(tx_ack), .tx_fail(tx_fail),
    .phy_cal_busy(phy_cal_busy), .pcs_lock(pcs_lock), .ctrl(ctrl),
    .tx_lane_en(tx_lane_en), .busy(busy), .done(done), .err(err)
  );

  typedef struct {
    logic [31:0] w;
    bit b, d, t;
    logic [1:0] e;
    bit st, ak, fl, cal, lk;
    string tag;
  } rec_t;

  rec_t q[$];
  logic [31:0] c;
  bit cal_in, lock_in;

  task automatic push(bit b, bit d, bit t, logic [1:0] e, bit ak, bit fl, string tag);
    rec_t r;
    r.w = c; r.b = b; r.d = d; r.t = t; r.e = e;
    r.st = 1'b0; r.ak = ak; r.fl = fl; r.cal = cal_in; r.lk = lock_in;
    r.tag = tag;
    q.push_back(r);
  endtask

  task automatic compare(rec_t r, int k);
    checks++;
    if (ctrl !== r.w || busy !== r.b || done !== r.d || tx_lane_en !== r.t || err !== r.e) begin
      errors++;
      $display("FAIL %s edge %0d ctrl=%h/%h busy=%0d/%0d done=%0d/%0d txen=%0d/%0d err=%0d/%0d",
               r.tag, k, ctrl, r.w, busy, r.b, done, r.d, tx_lane_en, r.t, err, r.e);
    end
  endtask

  // Build the expected timeline for one run, then play it edge by edge.
  task automatic run(int dly, bit txf, int p, int l, int ign);
    bit fin;
    rec_t r;
    q.delete();
    c = RSTW; cal_in = 1'b1; lock_in = 1'b0; fin = 1'b0;
    push(1, 0, 1, 2'd0, 0, 0, "R2");
    q[0].st = 1'b1;
    for (int i = 1; i < dly; i++) push(1, 0, 1, 2'd0, 0, 0, "R2");
    if (txf) begin
      push(0, 0, 0, 2'd1, 0, 1, "R2");
      fin = 1'b1;
    end else begin
      push(1, 0, 1, 2'd0, 1, 0, "R2");
      c[31] = 1'b1;    push(1, 0, 1, 2'd0, 0, 0, "R3");
      c[4] = 1'b0;     push(1, 0, 1, 2'd0, 0, 0, "R3");
      c[5] = 1'b0;     push(1, 0, 1, 2'd0, 0, 0, "R3");
      c[7:6] = 2'b00;  push(1, 0, 1, 2'd0, 0, 0, "R3");
      c[8] = 1'b1;     push(1, 0, 1, 2'd0, 0, 0, "R3");
      for (int pl = 1; pl <= CT; pl++) begin
        if (pl == p) begin
          cal_in = 1'b0; c[8] = 1'b0;
          push(1, 0, 1, 2'd0, 0, 0, "R4");
          break;
        end else if (pl == CT) begin
          push(0, 0, 1, 2'd2, 0, 0, "R5");
          fin = 1'b1;
        end else begin
          push(1, 0, 1, 2'd0, 0, 0, "R4");
          for (int w = 0; w < MS; w++) push(1, 0, 1, 2'd0, 0, 0, "R4");
        end
      end
    end
    if (!fin) begin
      c[0] = 1'b1; push(1, 0, 1, 2'd0, 0, 0, "R6");
      for (int a = 1; a <= LT; a++) begin
        c[9] = 1'b1;  push(1, 0, 1, 2'd0, 0, 0, "R7");
        c[9] = 1'b0;  push(1, 0, 1, 2'd0, 0, 0, "R7");
        c[10] = 1'b1; push(1, 0, 1, 2'd0, 0, 0, "R7");
        if (a == l) begin
          lock_in = 1'b1;
          push(0, 1, 1, 2'd0, 0, 0, "R8");
          break;
        end else if (a == LT) begin
          push(0, 0, 1, 2'd3, 0, 0, "R8");
        end else begin
          push(1, 0, 1, 2'd0, 0, 0, "R8");
          for (int w = 0; w < MS; w++) push(1, 0, 1, 2'd0, 0, 0, "R8");
        end
      end
    end
    r = q[q.size()-1];
    for (int i = 0; i < 4; i++) push(r.b, r.d, r.t, r.e, 0, 0, "R10");
    if (ign > 0) begin
      q[ign].st = 1'b1;
      q[ign].tag = "R9";
    end
    for (int k = 0; k < q.size(); k++) begin
      start = q[k].st; tx_ack = q[k].ak; tx_fail = q[k].fl;
      phy_cal_busy = q[k].cal; pcs_lock = q[k].lk;
      @(posedge clk);
      @(negedge clk);
      compare(q[k], k);
    end
    start = 1'b0; tx_ack = 1'b0; tx_fail = 1'b0; pcs_lock = 1'b0; phy_cal_busy = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rec_t r0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r0.w = RSTW; r0.b = 0; r0.d = 0; r0.t = 0; r0.e = 2'd0; r0.tag = "R1";
    compare(r0, 0);
    rst = 1'b0;
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      compare(r0, 0);
    end
    run(1, 0, 1, 1, 0);        // fastest path
    run(3, 0, 3, 3, 9);        // delayed ack, mid-run start ignored (R9)
    run(2, 0, CT, LT, 0);      // last allowed poll and attempt
    run(1, 0, CT + 1, 1, 0);   // calibration timeout R5
    run(1, 0, 2, LT + 1, 12);  // lock failure R8, start ignored R9
    run(2, 1, 1, 1, 0);        // transmit failure R2
    run(1, 0, 1, 2, 0);        // restart after failure reloads word R2
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule